// File: doc/BRIEF.md
# Hash Accelerator Register Front End

This block is the memory-mapped face of a block-hash engine that runs either SHA-1 or MD5. Software programs a chunk through a control register: the algorithm, whether the engine starts from its built-in initial values or from a digest and byte count that software wrote back earlier, whether this chunk closes the message, and the chunk length in bytes. The front end then collects message words through an input window, fed by the processor or by a DMA engine, one 64-byte block at a time. It hands each full block to a compression core through a start/done port and keeps the running digest and byte count. When the chunk ends it raises output-ready and, if enabled, a level interrupt.

Digest and byte-count registers stay readable and writable between chunks, so one request can be suspended and another hashed in between. The saved context is restored before the next chunk runs. The compression rounds and the padding arithmetic are outside the block: the core receives the block, the number of valid bytes in it, the running total, and first/last flags.

Top module: `hsh_front`

## Requirements
- R1: After reset every register reads zero, except reset-done (offset 0x64 bit 0), which reads 1, and the revision word at 0x5C, which reads the REV_ID parameter. irq, dma_req, clk_req and core_start are low.
- R2: A control write (offset 0x18) with bit 0 clear and a nonzero length in bits 31:5, while no chunk is active, starts a chunk. Input-ready (control bit 1) rises. Blocks go to the core with core_bytes = min(64, bytes left). core_sha1 equals control bit 2. core_load_iv is high only on the first block, and only when bit 3 was set. core_close is high only on the last block, and only when bit 4 was set.
- R3: Accepted writes anywhere in the window 0x1C..0x58 fill the next block slot in arrival order, whatever their offset. Slot k appears on core_block[32k+31:32k]. A block takes ceil(bytes/4) words. Window writes made while input-ready is low are dropped.
- R4: Input-ready is low from the issue of a block until the core reports done. It rises again only if bytes of the chunk remain.
- R5: The byte count (0x14) restarts from 0 when bit 3 is set. Otherwise it continues from the value software wrote. It grows by core_bytes after each block, and core_total is the count including the current block.
- R6: Digest words sit at 0x00, 0x04, ... 0x10. The core result is captured after each block. With SHA-1 a word reads exactly as the core produced it; with MD5 its four bytes are reversed. Software writes go through the same mapping, and with bit 3 clear they are what the core receives on core_dig_in.
- R7: Output-ready (control bit 0) sets when the last block of a chunk completes and clears when 1 is written to bit 0. Such a write changes no other control field and starts nothing. irq equals output-ready while interrupt enable (0x60 bit 2) is set.
- R8: With DMA enable (0x60 bit 3) set, dma_req is high while input-ready is high and the current block holds no word yet. The first accepted word drops it.
- R9: Writing 1 to 0x60 bit 1 clears all registers and any active chunk. For RST_CYCLES cycles reset-done reads 0 and mask bit 1 reads 1, then reset-done returns to 1.
- R10: A start with both bit 3 and bit 4 set and a length below 9 bytes is refused: no block is issued and input-ready stays low. A length of exactly 9 is accepted.
- R11: clk_req is high while the stored length field is nonzero or a chunk is active. A control write of length zero while idle drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Level completion interrupt |
| dma_req | output | 1 | Request for a 16-word packet |
| clk_req | output | 1 | Engine needs its clock |
| core_start | output | 1 | One-cycle block issue |
| core_load_iv | output | 1 | Start from initial constants |
| core_close | output | 1 | Block ends the message |
| core_sha1 | output | 1 | 1 = SHA-1, 0 = MD5 |
| core_bytes | output | 7 | Valid bytes in this block |
| core_total | output | CNT_W | Message bytes including this block |
| core_block | output | 512 | Sixteen collected words |
| core_dig_in | output | 160 | Digest the core continues from |
| core_done | input | 1 | Core finished the block |
| core_dig_out | input | 160 | Digest after the block |

## Verification
The bench uses the default CNT_W of 32, RST_CYCLES of 4 and its own REV_ID, plus a behavioural core with a 4-cycle latency. The short reset window lets the bench watch reset-done drop and return without long waits. The core latency leaves time to read input-ready while a block is in flight and to push a stray word the block must drop. The 32-bit count allows a restored count of 0x1000, which shows the count continuing from the written value rather than restarting.

// File: rtl/hsh_pkg.sv
package hsh_pkg;
  localparam int WORD_W        = 32;
  localparam int BLK_WORDS     = 16;
  localparam int BLK_BYTES     = BLK_WORDS * 4;
  localparam int DIG_WORDS     = 5;
  localparam int FILL_W        = $clog2(BLK_WORDS + 1);
  localparam int SLOT_W        = $clog2(BLK_WORDS);
  localparam int LEN_LSB       = 5;
  localparam int LEN_W         = WORD_W - LEN_LSB;
  localparam int MIN_MSG_BYTES = 9;

  // byte offsets; the input window spans BLK_WORDS words from A_DIN0
  localparam logic [7:0] A_COUNT = 8'h14;
  localparam logic [7:0] A_CTRL  = 8'h18;
  localparam logic [7:0] A_DIN0  = 8'h1C;
  localparam logic [7:0] A_REV   = 8'h5C;
  localparam logic [7:0] A_MASK  = 8'h60;
  localparam logic [7:0] A_SYS   = 8'h64;

  // control and mask bit positions
  localparam int C_ORDY = 0;
  localparam int C_IRDY = 1;
  localparam int C_SHA  = 2;
  localparam int C_IV   = 3;
  localparam int C_LAST = 4;
  localparam int M_SRST = 1;
  localparam int M_IRQ  = 2;
  localparam int M_DMA  = 3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FILL, SQ_RUN} seq_state_t;

  function automatic logic [31:0] byte_rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // SHA-1 words pass straight through; MD5 words are shown byte-reversed
  function automatic logic [31:0] to_bus(input logic sha, input logic [31:0] w);
    return sha ? w : byte_rev(w);
  endfunction

  function automatic logic [FILL_W-1:0] words_needed(input logic [6:0] nbytes);
    return FILL_W'((8'(nbytes) + 8'd3) >> 2);
  endfunction

  function automatic logic in_window(input logic [7:0] a);
    return (a >= A_DIN0) && (a < A_REV) && (a[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/hsh_inbuf.sv
module hsh_inbuf import hsh_pkg::*; (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr_en,
  input  logic [31:0]               wdata,
  output logic [FILL_W-1:0]         fill,
  output logic [BLK_WORDS*32-1:0]   block
);
  logic [31:0] slot [BLK_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < BLK_WORDS; i++) slot[i] <= '0;
    end else if (clr) begin
      fill <= '0;
    end else if (wr_en) begin
      slot[fill[SLOT_W-1:0]] <= wdata;
      fill <= fill + 1'b1;
    end
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_slot
    assign block[g*32 +: 32] = slot[g];
  end
endmodule

// File: rtl/hsh_seq.sv
module hsh_seq import hsh_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              go,
  input  logic [LEN_W-1:0]  go_len,
  input  logic              go_first,
  input  logic              go_close,
  input  logic [FILL_W-1:0] fill,
  input  logic              core_done,
  output logic              in_ready,
  output logic              blk_start,
  output logic              blk_first,
  output logic              blk_last,
  output logic              blk_done,
  output logic              chunk_end,
  output logic              active,
  output logic [6:0]        blk_bytes
);
  seq_state_t       st;
  logic [LEN_W-1:0] rem;
  logic             first_q, close_q, full;

  assign blk_bytes = (rem >= LEN_W'(BLK_BYTES)) ? 7'(BLK_BYTES) : rem[6:0];
  assign full      = (st == SQ_FILL) && (fill == words_needed(blk_bytes));
  assign in_ready  = (st == SQ_FILL) && !full;
  assign blk_start = full;
  assign blk_first = first_q;
  assign blk_last  = close_q && (rem <= LEN_W'(BLK_BYTES));
  assign blk_done  = (st == SQ_RUN) && core_done;
  assign chunk_end = blk_done && (rem == LEN_W'(blk_bytes));
  assign active    = (st != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; rem <= '0; first_q <= 1'b0; close_q <= 1'b0;
    end else if (clr) begin
      st <= SQ_IDLE; rem <= '0; first_q <= 1'b0; close_q <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: if (go) begin
          st <= SQ_FILL; rem <= go_len; first_q <= go_first; close_q <= go_close;
        end
        SQ_FILL: if (full) st <= SQ_RUN;
        SQ_RUN: if (core_done) begin
          rem     <= rem - LEN_W'(blk_bytes);
          first_q <= 1'b0;
          st      <= (rem == LEN_W'(blk_bytes)) ? SQ_IDLE : SQ_FILL;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsh_softrst.sv
module hsh_softrst #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (kick)       cnt <= CW'(RST_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign busy = (cnt != '0);
endmodule

// File: rtl/hsh_front.sv
module hsh_front import hsh_pkg::*; #(
  parameter int          CNT_W      = 32,
  parameter int          RST_CYCLES = 4,
  parameter logic [31:0] REV_ID     = 32'h0000_0021
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [7:0]                  bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        irq,
  output logic                        dma_req,
  output logic                        clk_req,
  output logic                        core_start,
  output logic                        core_load_iv,
  output logic                        core_close,
  output logic                        core_sha1,
  output logic [6:0]                  core_bytes,
  output logic [CNT_W-1:0]            core_total,
  output logic [BLK_WORDS*32-1:0]     core_block,
  output logic [DIG_WORDS*32-1:0]     core_dig_in,
  input  logic                        core_done,
  input  logic [DIG_WORDS*32-1:0]     core_dig_out
);
  logic wr, ev_ctrl_wr, ev_cnt_wr, ev_mask_wr, ev_din_wr, ev_dig_wr, ev_oready_clr;
  logic srst_busy, srst_kick, go_req, go;
  logic in_ready, blk_start, blk_first, blk_last, blk_done, chunk_end, active;
  logic [6:0]        blk_bytes;
  logic [FILL_W-1:0] fill;
  logic              algo_q, loadc_q, close_q, oready_q, irq_en_q, dma_en_q;
  logic [LEN_W-1:0]  len_q, wr_len;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       dig_q [DIG_WORDS];
  logic [31:0]       rd_mux;

  // register decode, brought out as named events
  assign wr            = bus_sel && bus_we;
  assign ev_ctrl_wr    = wr && (bus_addr == A_CTRL);
  assign ev_cnt_wr     = wr && (bus_addr == A_COUNT) && !active;
  assign ev_mask_wr    = wr && (bus_addr == A_MASK);
  assign ev_din_wr     = wr && in_window(bus_addr);
  assign ev_dig_wr     = wr && (bus_addr < A_COUNT) && (bus_addr[1:0] == 2'b00) && !active;
  assign ev_oready_clr = ev_ctrl_wr && bus_wdata[C_ORDY];
  assign wr_len        = bus_wdata[WORD_W-1:LEN_LSB];
  assign go_req        = ev_ctrl_wr && !bus_wdata[C_ORDY] && !active && !srst_busy;
  assign go            = go_req && (wr_len != '0) &&
                         !(bus_wdata[C_IV] && bus_wdata[C_LAST] && (wr_len < LEN_W'(MIN_MSG_BYTES)));
  assign srst_kick     = ev_mask_wr && bus_wdata[M_SRST] && !srst_busy;

  hsh_softrst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst_n(rst_n), .kick(srst_kick), .busy(srst_busy));

  hsh_inbuf u_buf (
    .clk(clk), .rst_n(rst_n), .clr(srst_busy || go || blk_done),
    .wr_en(ev_din_wr && in_ready), .wdata(bus_wdata), .fill(fill), .block(core_block));

  hsh_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(srst_busy), .go(go), .go_len(wr_len),
    .go_first(bus_wdata[C_IV]), .go_close(bus_wdata[C_LAST]), .fill(fill),
    .core_done(core_done), .in_ready(in_ready), .blk_start(blk_start),
    .blk_first(blk_first), .blk_last(blk_last), .blk_done(blk_done),
    .chunk_end(chunk_end), .active(active), .blk_bytes(blk_bytes));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst_busy) begin
      {algo_q, loadc_q, close_q, oready_q, irq_en_q, dma_en_q} <= '0;
      len_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DIG_WORDS; i++) dig_q[i] <= '0;
    end else begin
      if (go_req) begin
        algo_q  <= bus_wdata[C_SHA];
        loadc_q <= bus_wdata[C_IV];
        close_q <= bus_wdata[C_LAST];
        len_q   <= wr_len;
      end
      if (chunk_end)          oready_q <= 1'b1;
      else if (ev_oready_clr) oready_q <= 1'b0;
      if (ev_mask_wr) begin
        irq_en_q <= bus_wdata[M_IRQ];
        dma_en_q <= bus_wdata[M_DMA];
      end
      if (go && bus_wdata[C_IV]) cnt_q <= '0;
      else if (blk_done)         cnt_q <= cnt_q + CNT_W'(blk_bytes);
      else if (ev_cnt_wr)        cnt_q <= CNT_W'(bus_wdata);
      for (int i = 0; i < DIG_WORDS; i++) begin
        if (blk_done)
          dig_q[i] <= to_bus(algo_q, core_dig_out[i*32 +: 32]);
        else if (ev_dig_wr && (bus_addr[4:2] == 3'(i)))
          dig_q[i] <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < DIG_WORDS; g++) begin : g_dig
    assign core_dig_in[g*32 +: 32] = to_bus(algo_q, dig_q[g]);
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr < A_COUNT) begin
      for (int i = 0; i < DIG_WORDS; i++)
        if (bus_addr[4:2] == 3'(i)) rd_mux = dig_q[i];
    end else begin
      case (bus_addr)
        A_COUNT: rd_mux = 32'(cnt_q);
        A_CTRL:  rd_mux = {len_q, close_q, loadc_q, algo_q, in_ready, oready_q};
        A_REV:   rd_mux = REV_ID;
        A_MASK:  rd_mux = {28'd0, dma_en_q, irq_en_q, srst_busy, 1'b0};
        A_SYS:   rd_mux = {31'd0, !srst_busy};
        default: rd_mux = '0;
      endcase
    end
  end

  assign bus_rdata    = (bus_sel && !bus_we) ? rd_mux : '0;
  assign irq          = oready_q && irq_en_q;
  assign dma_req      = dma_en_q && in_ready && (fill == '0);
  assign clk_req      = (len_q != '0) || active;
  assign core_start   = blk_start;
  assign core_load_iv = blk_first;
  assign core_close   = blk_last;
  assign core_sha1    = algo_q;
  assign core_bytes   = blk_bytes;
  assign core_total   = cnt_q + CNT_W'(blk_bytes);
endmodule

// File: rtl/hsh_front_chk.sv
module hsh_front_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic dma_req,
  input logic in_ready,
  input logic core_start,
  input logic oready,
  input logic blk_done,
  input logic ev_oready_clr,
  input logic ev_mask_wr,
  input logic srst_busy
);
  // R2: a block issue is a single-cycle pulse
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  // R4: no input is taken once a block has gone to the core
  assert_busy_no_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !in_ready);

  // R7: output-ready only rises after a block completes
  assert_ready_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oready) |-> $past(blk_done));

  // R7: the interrupt level holds until cleared or reconfigured
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ev_oready_clr && !ev_mask_wr) |=> irq);

  // R8: requests only while the window is open
  assert_dma_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> in_ready);

  // R9: soft reset keeps the window shut and issues nothing
  assert_srst_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_busy && $past(srst_busy)) |-> (!in_ready && !core_start));
endmodule

bind hsh_front hsh_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .dma_req(dma_req), .in_ready(in_ready),
  .core_start(core_start), .oready(oready_q), .blk_done(blk_done),
  .ev_oready_clr(ev_oready_clr), .ev_mask_wr(ev_mask_wr), .srst_busy(srst_busy)
);

// File: tb/tb_hsh_front.sv
module tb_hsh_front;
  import hsh_pkg::*;
  localparam int          RSTC = 4;
  localparam int          LAT  = 4;
  localparam logic [31:0] REV  = 32'h0000_0A17;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, dma_req, clk_req, core_start, core_load_iv, core_close, core_sha1;
  logic [6:0]   core_bytes;
  logic [31:0]  core_total;
  logic [511:0] core_block;
  logic [159:0] core_dig_in;
  logic         core_done = 0;
  logic [159:0] core_dig_out = '0;

  hsh_front #(.CNT_W(32), .RST_CYCLES(RSTC), .REV_ID(REV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req),
    .clk_req(clk_req), .core_start(core_start), .core_load_iv(core_load_iv),
    .core_close(core_close), .core_sha1(core_sha1), .core_bytes(core_bytes),
    .core_total(core_total), .core_block(core_block), .core_dig_in(core_dig_in),
    .core_done(core_done), .core_dig_out(core_dig_out));

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    bit          iv, cl, sha;
    int          bytes, nw;
    logic [31:0] total;
    logic [31:0] w [16];
    logic [31:0] din [5];
  } item_t;
  item_t       sb_q[$];
  logic [31:0] edig [5];
  logic [31:0] ecnt = 0;

  function automatic logic [31:0] swap4(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = w[8*(3-b) +: 8];
    return r;
  endfunction
  function automatic logic [31:0] iv_word(input int i);
    return 32'hC0DE_0000 + 32'(i);
  endfunction
  function automatic logic [31:0] dword(input int tag, input int k);
    return (32'(tag) << 24) ^ (32'(k) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [7:0] din_addr(input int j);
    return 8'(28 + 4 * ((j * 5) % 16));
  endfunction
  function automatic logic [31:0] cw(input int len, input bit cl, input bit iv, input bit sha);
    return (32'(len) << 5) | (32'(cl) << 4) | (32'(iv) << 3) | (32'(sha) << 2);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 v = bus_rdata; bus_sel = 0;
  endtask
  task automatic wait_bit(input int b, input string tag);
    logic [31:0] v;
    bit hit = 0;
    for (int n = 0; n < 200 && !hit; n++) begin rd(A_CTRL, v); hit = v[b]; end
    chk(tag, 32'(hit), 32'd1);
  endtask

  // monitor + behavioural core: pops the scoreboard on each block issue
  initial forever begin
    @(negedge clk);
    if (core_start) begin
      logic [159:0] o;
      int nw;
      nw = (int'(core_bytes) + 3) / 4;
      if (sb_q.size() == 0) begin
        chk("R2/R10 block issued with none expected", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk("R2 core_load_iv", 32'(core_load_iv), 32'(it.iv));
        chk("R2 core_close", 32'(core_close), 32'(it.cl));
        chk("R2 core_sha1", 32'(core_sha1), 32'(it.sha));
        chk("R2 core_bytes", 32'(core_bytes), 32'(it.bytes));
        chk("R5 core_total", core_total, it.total);
        for (int j = 0; j < it.nw; j++) chk("R3 block word", core_block[j*32 +: 32], it.w[j]);
        if (!it.iv) for (int i = 0; i < 5; i++) chk("R6 core_dig_in", core_dig_in[i*32 +: 32], it.din[i]);
      end
      for (int i = 0; i < 5; i++) begin
        logic [31:0] base, add;
        base = core_load_iv ? iv_word(i) : core_dig_in[i*32 +: 32];
        add  = (i < nw) ? core_block[i*32 +: 32] : 32'd0;
        o[i*32 +: 32] = base + add + core_total + 32'(i);
      end
      repeat (LAT) @(negedge clk);
      core_dig_out = o; core_done = 1;
      @(negedge clk); core_done = 0;
    end
  end

  // probe: 1 = input-ready probes (R2/R4/R3), 2 = DMA probes (R8)
  task automatic run_chunk(input int tag, input bit sha, input bit iv, input bit cl,
                           input int len, input int probe);
    int rem, k, blk;
    logic [31:0] v;
    bit firstb = 1;
    if (iv) ecnt = 0;
    rem = len; k = 0;
    while (rem > 0) begin
      item_t it;
      int b;
      b = (rem > 64) ? 64 : rem;
      it.iv = iv && firstb; it.cl = cl && (rem <= 64); it.sha = sha;
      it.bytes = b; it.nw = (b + 3) / 4; it.total = ecnt + 32'(b);
      for (int i = 0; i < 5; i++) it.din[i] = edig[i];
      for (int j = 0; j < 16; j++) it.w[j] = (j < it.nw) ? dword(tag, k + j) : 32'd0;
      sb_q.push_back(it);
      for (int i = 0; i < 5; i++)
        edig[i] = (it.iv ? iv_word(i) : edig[i]) + ((i < it.nw) ? it.w[i] : 32'd0)
                  + it.total + 32'(i);
      ecnt = it.total; k += it.nw; rem -= b; firstb = 0;
    end
    wr(A_CTRL, cw(len, cl, iv, sha));
    if (probe == 1) begin rd(A_CTRL, v); chk("R2 input-ready after start", 32'(v[C_IRDY]), 32'd1); end
    if (probe == 2) chk("R8 dma_req at empty block", 32'(dma_req), 32'd1);
    rem = len; k = 0; blk = 0;
    while (rem > 0) begin
      int b, nw;
      b = (rem > 64) ? 64 : rem; nw = (b + 3) / 4;
      wait_bit(C_IRDY, "R4 input-ready for next block");
      for (int j = 0; j < nw; j++) begin
        wr(din_addr(j), dword(tag, k + j));
        if (probe == 2 && blk == 0 && j == 0) chk("R8 dma_req drops after first word", 32'(dma_req), 32'd0);
      end
      if (probe == 1 && blk == 0) begin
        rd(A_CTRL, v); chk("R4 input-ready low while core busy", 32'(v[C_IRDY]), 32'd0);
        wr(din_addr(3), 32'hBAD0_BAD0);   // R3: dropped, next block must not see it
      end
      k += nw; rem -= b; blk++;
    end
    wait_bit(C_ORDY, "R7 output-ready at chunk end");
    chk("R2 all blocks issued", 32'(sb_q.size()), 32'd0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] rst_vals [5];
    for (int i = 0; i < 5; i++) edig[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_SYS, v);   chk("R1 reset-done", v, 32'd1);
    rd(A_CTRL, v);  chk("R1 control", v, 32'd0);
    rd(A_COUNT, v); chk("R1 count", v, 32'd0);
    rd(A_MASK, v);  chk("R1 mask", v, 32'd0);
    rd(A_REV, v);   chk("R1 revision", v, REV);
    rd(8'h00, v);   chk("R1 digest0", v, 32'd0);
    chk("R1 outputs low", {28'd0, irq, dma_req, clk_req, core_start}, 32'd0);

    wr(A_MASK, 32'h4);                     // interrupt enable
    wr(A_DIN0, 32'hDEAD_0001);             // R3: idle window writes dropped
    wr(A_DIN0, 32'hDEAD_0002);

    // chunk A: SHA-1, constants, closing, 100 bytes (64 + 36)
    run_chunk(1, 1, 1, 1, 100, 1);
    chk("R7 irq level", 32'(irq), 32'd1);
    rd(A_COUNT, v); chk("R5 count after chunk", v, 32'd100);
    for (int i = 0; i < 5; i++) begin rd(8'(4*i), v); chk("R6 SHA-1 digest read", v, edig[i]); end
    chk("R11 clk_req held by length", 32'(clk_req), 32'd1);
    wr(A_CTRL, 32'h1);
    chk("R7 irq cleared", 32'(irq), 32'd0);
    rd(A_CTRL, v); chk("R7 clear keeps fields", v, cw(100, 1, 1, 1));
    chk("R7 clear starts nothing", 32'(sb_q.size()), 32'd0);
    wr(A_CTRL, 32'h0);
    chk("R11 zero length drops clk_req", 32'(clk_req), 32'd0);

    // chunk B: MD5, irq disabled
    wr(A_MASK, 32'h0);
    run_chunk(2, 0, 1, 1, 70, 0);
    chk("R7 irq gated by enable", 32'(irq), 32'd0);
    for (int i = 0; i < 4; i++) begin rd(8'(4*i), v); chk("R6 MD5 digest byte-reversed", v, swap4(edig[i])); end
    wr(A_CTRL, 32'h1);

    // chunk C: restored SHA-1 context, not closing
    for (int i = 0; i < 5; i++) begin
      rst_vals[i] = 32'h1234_0000 + 32'(i * 7);
      wr(8'(4*i), rst_vals[i]);
      edig[i] = rst_vals[i];
    end
    wr(A_COUNT, 32'h1000); ecnt = 32'h1000;
    run_chunk(3, 1, 0, 0, 64, 0);
    rd(A_COUNT, v); chk("R5 count continues from restore", v, 32'h1040);
    wr(A_CTRL, 32'h1);

    // R10: 8-byte message refused, 9 accepted
    wr(A_CTRL, cw(8, 1, 1, 1));
    rd(A_CTRL, v); chk("R10 short message not started", 32'(v[C_IRDY]), 32'd0);
    repeat (8) @(negedge clk);
    chk("R10 no block issued", 32'(sb_q.size()), 32'd0);
    run_chunk(4, 1, 1, 1, 9, 0);
    wr(A_CTRL, 32'h1);

    // R8: DMA request
    wr(A_MASK, 32'h8);
    run_chunk(5, 1, 1, 1, 64, 2);
    wr(A_CTRL, 32'h1);

    // R9: soft reset
    wr(A_MASK, 32'h2);
    rd(A_SYS, v);  chk("R9 reset-done low", v, 32'd0);
    rd(A_MASK, v); chk("R9 reset bit reads set", 32'(v[M_SRST]), 32'd1);
    repeat (RSTC + 2) @(negedge clk);
    rd(A_SYS, v);   chk("R9 reset-done returns", v, 32'd1);
    rd(A_COUNT, v); chk("R9 count cleared", v, 32'd0);
    rd(8'h00, v);   chk("R9 digest cleared", v, 32'd0);
    rd(A_MASK, v);  chk("R9 mask cleared", v, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule